// File: doc/BRIEF.md
# Receive FIFO Flow Control Engine

This block sits beside the receive data FIFO of an Ethernet MAC and decides when the link partner must be asked to slow down. It divides the FIFO byte count into 64-byte units and compares the result with a programmable high-water mark and a programmable low-water mark.

In full duplex it asks the transmitter for one pause frame when the high mark is reached. That frame carries a programmable pause time. After the transmitter has sent it, the block asks for a resume frame with pause time zero once the level falls under the low mark. In half duplex it does not ask for pause frames. Instead, while the level is at or above the high mark, each arriving frame of an enabled type starts a back-pressure (jam) interval of programmable length.

The transmitter takes a pause request as a held level and returns a one-cycle acknowledge when it has accepted it. A disabled transmitter, or automatic flow control switched off, silences both outputs.

Top module: `rxfc_engine`

## Requirements
- R1: While reset is asserted and right after it is released, `pause_req` and `jam` are low.
- R2: In full duplex, a request is raised one cycle after the level (`fifo_bytes` divided by 64, rounded down) is first seen at or above `hi_lvl`. No further high-water request follows until the level has been seen below `lo_lvl`. This holds even if the level stays high or moves between the two marks.
- R3: A high-water request presents `pause_val` equal to the `pause_time` input.
- R4: A resume request with `pause_val` of zero is raised one cycle after the level is seen below `lo_lvl`, but only if a high-water request was acknowledged before that. A level exactly equal to `lo_lvl` does not count as below.
- R5: `pause_req` stays high until `pause_ack` is sampled high, and drops on the following clock edge.
- R6: The newest condition replaces a pending request. A resume request that is still waiting becomes a high-water request when the level reaches `hi_lvl` again. A high-water request that is still waiting is withdrawn, with no resume request, when the level falls below `lo_lvl`.
- R7: One cycle after `tx_en` or `fc_en` is sampled low, `pause_req` and `jam` are low and stay low while that input is low. A pending request is dropped.
- R8: In half duplex, with the level at or above `hi_lvl`, a cycle with `rx_sof` high and a matching enabled frame type drives `jam` high from the next cycle. It stays high for exactly (`jam_dur`+1)×`JAM_UNIT` cycles, where `JAM_UNIT` is 4 by default.
- R9: The frame-type enables decide which frames start a jam. A frame whose types are all disabled does not start one, and neither does a frame that arrives in full duplex. In half duplex no pause request is raised.
- R10: A frame that arrives while the level is below `hi_lvl` does not start a jam.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_bytes | input | CNT_W (14) | Bytes currently held in the receive FIFO |
| hi_lvl | input | TH_W (8) | High-water mark in 64-byte units |
| lo_lvl | input | TH_W (8) | Low-water mark in 64-byte units, must be below hi_lvl |
| pause_time | input | PT_W (16) | Pause time carried by a high-water request |
| jam_dur | input | DUR_W (4) | Back-pressure duration code |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_en | input | 1 | Transmitter enabled |
| fc_en | input | 1 | Automatic flow control enabled |
| en_mcast | input | 1 | Jam on multicast frames |
| en_bcast | input | 1 | Jam on broadcast frames |
| en_own | input | 1 | Jam on frames addressed to this station |
| rx_sof | input | 1 | One-cycle pulse at the start of a received frame |
| rx_mcast | input | 1 | Frame is multicast (valid with rx_sof) |
| rx_bcast | input | 1 | Frame is broadcast (valid with rx_sof) |
| rx_own | input | 1 | Frame matches the station address (valid with rx_sof) |
| pause_ack | input | 1 | Transmitter accepted the pending pause request |
| pause_req | output | 1 | Pause frame request, held until acknowledged |
| pause_val | output | PT_W (16) | Pause time of the pending request |
| jam | output | 1 | Half-duplex back pressure |

## Verification
The assertions check, on every cycle, the rules that can be seen from one or two cycles of port history. Both outputs fall silent after the transmitter or flow control is switched off. Jam is absent in full duplex and pause requests are absent in half duplex. A new request shows either zero or the programmed pause time, and only after the matching threshold crossing. A jam interval starts only after a half-duplex frame start. Other behaviours depend on longer history and are shown only by the bench scenarios: the single request per high-water episode, the resume that depends on an earlier acknowledge, the newest-wins replacement of a pending request, and the exact jam length for each duration code and frame type.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  // FIFO byte count to 64-byte units
  localparam int UNIT_SHIFT = 6;

  typedef enum logic {
    PK_STOP   = 1'b0,
    PK_RESUME = 1'b1
  } pkind_e;
endpackage

// File: rtl/rxfc_level_cmp.sv
module rxfc_level_cmp #(
  parameter int CNT_W = 14,
  parameter int TH_W  = 8
) (
  input  logic [CNT_W-1:0] fifo_bytes,
  input  logic [TH_W-1:0]  hi_lvl,
  input  logic [TH_W-1:0]  lo_lvl,
  output logic             at_hi,
  output logic             below_lo
);
  import rxfc_pkg::*;

  localparam int W = (CNT_W > TH_W) ? CNT_W : TH_W;

  logic [W-1:0] units, hi_w, lo_w;

  assign units    = W'(fifo_bytes >> UNIT_SHIFT);
  assign hi_w     = W'(hi_lvl);
  assign lo_w     = W'(lo_lvl);
  assign at_hi    = (units >= hi_w);
  assign below_lo = (units <  lo_w);
endmodule

// File: rtl/rxfc_pause_seq.sv
module rxfc_pause_seq #(
  parameter int PT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            at_hi,
  input  logic            below_lo,
  input  logic            ack,
  input  logic [PT_W-1:0] pause_time,
  output logic            pause_req,
  output logic [PT_W-1:0] pause_val
);
  import rxfc_pkg::*;

  logic   req_q, req_d;
  logic   sent_q, sent_d;
  logic   armed_q, armed_d;
  pkind_e kind_q, kind_d;
  logic   upd;

  always_comb begin
    req_d   = req_q;
    kind_d  = kind_q;
    sent_d  = sent_q;
    armed_d = armed_q;
    if (!active) begin
      req_d = 1'b0;
    end else begin
      if (req_q && ack) begin
        req_d  = 1'b0;
        sent_d = (kind_q == PK_STOP);
      end
      if (armed_q && at_hi) begin
        req_d   = 1'b1;
        kind_d  = PK_STOP;
        armed_d = 1'b0;
      end else if (!armed_q && below_lo) begin
        armed_d = 1'b1;
        if (sent_d) begin
          req_d  = 1'b1;
          kind_d = PK_RESUME;
        end else if (req_d && kind_d == PK_STOP) begin
          req_d = 1'b0;
        end
      end
    end
  end

  assign upd = (req_d != req_q) || (kind_d != kind_q) ||
               (sent_d != sent_q) || (armed_d != armed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      kind_q  <= PK_STOP;
      sent_q  <= 1'b0;
      armed_q <= 1'b1;
    end else if (upd) begin
      req_q   <= req_d;
      kind_q  <= kind_d;
      sent_q  <= sent_d;
      armed_q <= armed_d;
    end
  end

  assign pause_req = req_q;
  assign pause_val = (kind_q == PK_RESUME) ? '0 : pause_time;
endmodule

// File: rtl/rxfc_jam_timer.sv
module rxfc_jam_timer #(
  parameter int DUR_W    = 4,
  parameter int JAM_UNIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             trig,
  input  logic [DUR_W-1:0] dur,
  output logic             jam
);
  localparam int MAX_CYC = (2 ** DUR_W) * JAM_UNIT;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d, load_val;
  logic          upd;

  assign load_val = CW'((int'(dur) + 1) * JAM_UNIT);

  always_comb begin
    cnt_d = cnt_q;
    if (!active)          cnt_d = '0;
    else if (trig)        cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  assign upd = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign jam = (cnt_q != '0);
endmodule

// File: rtl/rxfc_engine.sv
module rxfc_engine #(
  parameter int CNT_W    = 14,
  parameter int TH_W     = 8,
  parameter int PT_W     = 16,
  parameter int DUR_W    = 4,
  parameter int JAM_UNIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_bytes,
  input  logic [TH_W-1:0]  hi_lvl,
  input  logic [TH_W-1:0]  lo_lvl,
  input  logic [PT_W-1:0]  pause_time,
  input  logic [DUR_W-1:0] jam_dur,
  input  logic             full_duplex,
  input  logic             tx_en,
  input  logic             fc_en,
  input  logic             en_mcast,
  input  logic             en_bcast,
  input  logic             en_own,
  input  logic             rx_sof,
  input  logic             rx_mcast,
  input  logic             rx_bcast,
  input  logic             rx_own,
  input  logic             pause_ack,
  output logic             pause_req,
  output logic [PT_W-1:0]  pause_val,
  output logic             jam
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic at_hi, below_lo;
  logic fd_active, hd_active, type_hit, jam_trig;

  rxfc_level_cmp #(.CNT_W(CNT_W), .TH_W(TH_W)) u_cmp (
    .fifo_bytes (fifo_bytes),
    .hi_lvl     (hi_lvl),
    .lo_lvl     (lo_lvl),
    .at_hi      (at_hi),
    .below_lo   (below_lo)
  );

  assign fd_active = tx_en & fc_en &  full_duplex;
  assign hd_active = tx_en & fc_en & ~full_duplex;
  assign type_hit  = (en_mcast & rx_mcast) | (en_bcast & rx_bcast) | (en_own & rx_own);
  assign jam_trig  = rx_sof & type_hit & at_hi;

  rxfc_pause_seq #(.PT_W(PT_W)) u_pause (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .active     (fd_active),
    .at_hi      (at_hi),
    .below_lo   (below_lo),
    .ack        (pause_ack),
    .pause_time (pause_time),
    .pause_req  (pause_req),
    .pause_val  (pause_val)
  );

  rxfc_jam_timer #(.DUR_W(DUR_W), .JAM_UNIT(JAM_UNIT)) u_jam (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .active (hd_active),
    .trig   (jam_trig),
    .dur    (jam_dur),
    .jam    (jam)
  );
endmodule

// File: rtl/rxfc_engine_chk.sv
module rxfc_engine_chk #(
  parameter int CNT_W = 14,
  parameter int TH_W  = 8,
  parameter int PT_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] fifo_bytes,
  input logic [TH_W-1:0]  hi_lvl,
  input logic [TH_W-1:0]  lo_lvl,
  input logic [PT_W-1:0]  pause_time,
  input logic             full_duplex,
  input logic             tx_en,
  input logic             fc_en,
  input logic             rx_sof,
  input logic             pause_req,
  input logic [PT_W-1:0]  pause_val,
  input logic             jam
);
  logic lvl_hi, lvl_lo;
  assign lvl_hi = int'(fifo_bytes >> 6) >= int'(hi_lvl);
  assign lvl_lo = int'(fifo_bytes >> 6) <  int'(lo_lvl);

  a_r7_pause_silenced: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || !fc_en) |=> !pause_req);

  a_r7_jam_silenced: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || !fc_en) |=> !jam);

  a_r9_no_jam_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |=> !jam);

  a_r9_no_pause_half: assert property (@(posedge clk) disable iff (!rst_n)
    !full_duplex |=> !pause_req);

  a_r3_val_source: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> (pause_val == '0 || pause_val == pause_time));

  a_r2_stop_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pause_req) && pause_val != '0) |-> $past(lvl_hi));

  a_r4_resume_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pause_req) && pause_val == '0 && pause_time != '0) |-> $past(lvl_lo));

  a_r8_jam_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam) |-> $past(rx_sof && !full_duplex && tx_en && fc_en));
endmodule

bind rxfc_engine rxfc_engine_chk #(.CNT_W(CNT_W), .TH_W(TH_W), .PT_W(PT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_bytes  (fifo_bytes),
  .hi_lvl      (hi_lvl),
  .lo_lvl      (lo_lvl),
  .pause_time  (pause_time),
  .full_duplex (full_duplex),
  .tx_en       (tx_en),
  .fc_en       (fc_en),
  .rx_sof      (rx_sof),
  .pause_req   (pause_req),
  .pause_val   (pause_val),
  .jam         (jam)
);

// File: tb/rxfc_engine_test.sv
module rxfc_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] fifo_bytes;
  logic [7:0]  hi_lvl, lo_lvl;
  logic [15:0] pause_time;
  logic [3:0]  jam_dur;
  logic        full_duplex, tx_en, fc_en, en_mcast, en_bcast, en_own;
  logic        rx_sof, rx_mcast, rx_bcast, rx_own, pause_ack;
  logic        pause_req, jam;
  logic [15:0] pause_val;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  bit auto_ack = 1'b0;

  always #10 clk = ~clk;

  rxfc_engine uut (
    .clk(clk), .rst_n(rst_n), .fifo_bytes(fifo_bytes), .hi_lvl(hi_lvl),
    .lo_lvl(lo_lvl), .pause_time(pause_time), .jam_dur(jam_dur),
    .full_duplex(full_duplex), .tx_en(tx_en), .fc_en(fc_en),
    .en_mcast(en_mcast), .en_bcast(en_bcast), .en_own(en_own),
    .rx_sof(rx_sof), .rx_mcast(rx_mcast), .rx_bcast(rx_bcast), .rx_own(rx_own),
    .pause_ack(pause_ack), .pause_req(pause_req), .pause_val(pause_val), .jam(jam)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_level(input int bytes, input int settle);
    fifo_bytes = 14'(bytes);
    wait_cyc(settle);
  endtask

  // monitor: pops the scoreboard and acknowledges each request
  always @(negedge clk) begin
    pause_ack <= 1'b0;
    if (auto_ack && pause_req && !pause_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected request", int'(pause_val), -1);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(pause_val == e, "R3/R4 pause value", int'(pause_val), int'(e));
      end
      pause_ack <= 1'b1;
    end
  end

  task automatic frame(input bit m, input bit b, input bit o, input int exp_n, input string req);
    int n;
    rx_sof = 1'b1; rx_mcast = m; rx_bcast = b; rx_own = o;
    @(negedge clk);
    rx_sof = 1'b0; rx_mcast = 1'b0; rx_bcast = 1'b0; rx_own = 1'b0;
    n = 0;
    while (jam && n < 300) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp_n, req, n, exp_n);
    wait_cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fifo_bytes = '0; hi_lvl = 8'd10; lo_lvl = 8'd4;
    pause_time = 16'h1234; jam_dur = 4'd0; full_duplex = 1'b1;
    tx_en = 1'b1; fc_en = 1'b1; en_mcast = 1'b0; en_bcast = 1'b0; en_own = 1'b0;
    rx_sof = 1'b0; rx_mcast = 1'b0; rx_bcast = 1'b0; rx_own = 1'b0; pause_ack = 1'b0;
    wait_cyc(3);
    chk(!pause_req && !jam, "R1 in reset", int'({pause_req, jam}), 0);
    rst_n = 1'b1;
    wait_cyc(4);
    chk(!pause_req && !jam, "R1 after release", int'({pause_req, jam}), 0);
    auto_ack = 1'b1;

    // R4: low level without an earlier pause gives nothing
    set_level(100, 8);
    chk(exp_q.size() == 0 && !pause_req, "R4 no resume without pause", int'(pause_req), 0);

    // R2/R3: exact high mark (640 bytes = 10 units)
    exp_q.push_back(16'h1234);
    set_level(640, 10);
    chk(exp_q.size() == 0, "R2 pause at high mark", exp_q.size(), 0);
    set_level(900, 10);
    set_level(500, 10);
    set_level(320, 10);
    set_level(256, 10);   // exactly lo_lvl: not below
    chk(exp_q.size() == 0 && !pause_req, "R2 single pause, no early resume", int'(pause_req), 0);
    exp_q.push_back(16'h0000);
    set_level(255, 10);   // 3 units: below
    chk(exp_q.size() == 0, "R4 resume below low mark", exp_q.size(), 0);

    // second episode, with a different pause time
    pause_time = 16'h00A5;
    exp_q.push_back(16'h00A5);
    set_level(900, 10);
    chk(exp_q.size() == 0, "R2 re-armed after low", exp_q.size(), 0);
    pause_time = 16'h1234;

    // R6: pending resume replaced by a new high-water request
    auto_ack = 1'b0;
    set_level(100, 3);
    chk(pause_req && pause_val == 16'h0, "R4 resume pending", int'(pause_val), 0);
    set_level(900, 3);
    chk(pause_req && pause_val == 16'h1234, "R6 resume replaced", int'(pause_val), 16'h1234);
    wait_cyc(5);
    chk(pause_req == 1'b1, "R5 held without ack", int'(pause_req), 1);
    exp_q.push_back(16'h1234);
    auto_ack = 1'b1;
    wait_cyc(2);
    chk(!pause_req && exp_q.size() == 0, "R5 dropped after ack", int'(pause_req), 0);
    exp_q.push_back(16'h0000);
    set_level(100, 10);
    chk(exp_q.size() == 0, "R4 resume after replaced pause", exp_q.size(), 0);

    // R6: pending high-water request withdrawn by a fall below low
    auto_ack = 1'b0;
    set_level(900, 3);
    chk(pause_req && pause_val == 16'h1234, "R6 stop pending", int'(pause_val), 16'h1234);
    set_level(100, 3);
    chk(!pause_req, "R6 stale stop withdrawn", int'(pause_req), 0);
    auto_ack = 1'b1;
    wait_cyc(10);
    chk(exp_q.size() == 0 && !pause_req, "R6 no resume after withdrawal", int'(pause_req), 0);

    // R7: transmitter disabled drops a pending request
    auto_ack = 1'b0;
    set_level(900, 3);
    chk(pause_req == 1'b1, "R7 setup pending", int'(pause_req), 1);
    tx_en = 1'b0;
    wait_cyc(2);
    chk(!pause_req, "R7 dropped on tx disable", int'(pause_req), 0);
    set_level(100, 3);
    tx_en = 1'b1;
    wait_cyc(3);
    tx_en = 1'b0;
    set_level(900, 5);
    chk(!pause_req, "R7 no request with tx off", int'(pause_req), 0);
    set_level(100, 2);
    tx_en = 1'b1;
    auto_ack = 1'b1;
    wait_cyc(3);

    // half duplex
    full_duplex = 1'b0;
    set_level(900, 6);
    chk(!pause_req && exp_q.size() == 0, "R9 no pause in half duplex", int'(pause_req), 0);
    en_mcast = 1'b1; jam_dur = 4'd0;
    frame(1, 0, 0, 4, "R8 multicast jam code 0");
    jam_dur = 4'd3;
    frame(1, 0, 0, 16, "R8 multicast jam code 3");
    frame(0, 1, 0, 0, "R9 broadcast disabled");
    en_own = 1'b1; jam_dur = 4'd1;
    frame(0, 0, 1, 8, "R8 own address jam code 1");
    en_bcast = 1'b1; jam_dur = 4'd15;
    frame(0, 1, 0, 64, "R8 broadcast jam code 15");
    set_level(500, 2);
    frame(1, 1, 1, 0, "R10 below high mark");
    set_level(900, 2);
    tx_en = 1'b0;
    frame(1, 0, 0, 0, "R7 no jam with tx off");
    tx_en = 1'b1; fc_en = 1'b0;
    frame(1, 0, 0, 0, "R7 no jam with flow control off");
    fc_en = 1'b1;

    // full duplex frame: no jam, level high so one pause expected
    exp_q.push_back(16'h1234);
    full_duplex = 1'b1;
    frame(1, 1, 1, 0, "R9 no jam in full duplex");
    wait_cyc(5);
    chk(exp_q.size() == 0, "R2 pause after mode change", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule